// File: doc/BRIEF.md
# Inter-core mailbox transmit inbox

This block is the sending half of a mailbox between processor cores. The local processor loads a 64-bit payload into two 32-bit data registers and picks a destination with a target register. A write to the launch register then places the payload into that destination's one-entry slot. There are eight destinations, each with its own slot. The remote side drains a slot with a one-cycle fetch pulse on that destination's line. A select input and a message output let the remote side see the contents of any slot.

Each destination has three status bits, all packed into one status word: a busy flag, a sticky "taken" flag and a sticky "dropped" flag. The busy flag is set while the payload waits for the remote side. The taken flag records that the remote side fetched the payload. The dropped flag records that a launch hit a slot that was still occupied. Software clears the sticky flags by writing the same bit pattern to a separate acknowledge register.

An interrupt line combines a pending flag with three maskable causes. The pending flag is set by a fetch or a dropped launch, and is cleared by software.

Top module: `mbx_tx_inbox`

## Requirements
- R1: A write to offset 0x0C with wdata bit 0 = 1 launches toward the destination held in bits 2:0 of offset 0x00. If that slot is idle, it captures {word at 0x08, word at 0x04} and sets busy bit n (status offset 0x14, bits 7:0, bit n for destination n). A write to 0x0C with bit 0 = 0 has no effect.
- R2: When rmt_sel = n, rmt_msg shows slot n's payload: the high word in bits 63:32 and the low word in bits 31:0.
- R3: A launch toward a busy destination n sets dropped bit 8+n of the status word. The busy bit stays set and the slot keeps its earlier payload.
- R4: A fetch pulse on rmt_fetch[n] while destination n is busy clears busy bit n and sets taken bit 16+n. A fetch pulse on an idle destination changes nothing.
- R5: A write to offset 0x10 clears the taken bits (wdata 23:16) and dropped bits (wdata 15:8) whose wdata bits are 1, and leaves all other bits unchanged. Busy bits are not affected by this write.
- R6: Offset 0x1C holds a 3-bit mask: bit 0 for the dropped-launch event, bit 1 for any dropped bit, bit 2 for any taken bit. A 1 masks that cause, and the value after reset is 3'b111.
- R7: Bit 0 of offset 0x18 is a pending flag. It is set by an accepted fetch or a dropped launch, and cleared by writing 1 to bit 0 of 0x18. If a set event and the clear come in the same cycle, the set wins.
- R8: irq is the pending flag AND the OR of the unmasked causes. The dropped-launch cause stays active from the launch until the pending flag is cleared.
- R9: After reset the status word reads 0, the pending flag reads 0 and irq is low.
- R10: Offsets 0x00, 0x04 and 0x08 read back the last value written to them (the target register reads as its 3-bit field).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rmt_fetch | input | 8 | Per-destination fetch pulse from the remote side |
| rmt_sel | input | 3 | Slot shown on rmt_msg |
| rmt_msg | output | 64 | Payload of the selected slot |
| irq | output | 1 | Interrupt request |

## Verification
The bench launches a second payload into a slot that is still occupied. A design that overwrites the slot, or that clears or fails to keep busy, shows the wrong payload or status. It clears the taken and dropped bits one destination at a time. A clear that hits whole fields, or that touches busy, leaves the wrong status word. It walks the mask through each cause on its own. This catches a mask with swapped bits, a dropped-launch cause that does not persist, and an interrupt that ignores the pending flag. It also sends fetch pulses to idle slots and launch writes with bit 0 low. A design that acts on either changes the status word.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 6;
    localparam int FIELD_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_TARGET = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_LOW    = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_HIGH   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_LAUNCH = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h1C;

    localparam int BUSY_LSB  = 0;
    localparam int DROP_LSB  = 8;
    localparam int TAKEN_LSB = 16;

    // Mask bits: taken at 2, dropped at 1, dropped-launch event at 0
    typedef struct packed {
        logic taken;
        logic dropped;
        logic blocked;
    } irq_mask_t;

    localparam irq_mask_t MASK_RESET = '{taken: 1'b1, dropped: 1'b1, blocked: 1'b1};

    typedef struct packed {
        logic [REG_W-1:0] high;
        logic [REG_W-1:0] low;
    } payload_t;

    function automatic logic [REG_W-1:0] pack_status(
        input logic [FIELD_W-1:0] busy,
        input logic [FIELD_W-1:0] dropped,
        input logic [FIELD_W-1:0] taken
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[BUSY_LSB  +: FIELD_W] = busy;
        w[DROP_LSB  +: FIELD_W] = dropped;
        w[TAKEN_LSB +: FIELD_W] = taken;
        return w;
    endfunction

endpackage

// File: rtl/mbx_tx_slot.sv
module mbx_tx_slot
    import mbx_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  payload_t msg_in,
    input  logic     fetch,
    input  logic     clr_taken,
    input  logic     clr_drop,
    output logic     busy,
    output logic     taken,
    output logic     dropped,
    output payload_t msg,
    output logic     take_evt,
    output logic     drop_evt
);

    assign take_evt = fetch && busy;
    assign drop_evt = launch && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            taken   <= 1'b0;
            dropped <= 1'b0;
            msg     <= '0;
        end else begin
            if (launch && !busy) begin
                busy <= 1'b1;
                msg  <= msg_in;
            end else if (take_evt) begin
                busy <= 1'b0;
            end
            if (take_evt)       taken <= 1'b1;
            else if (clr_taken) taken <= 1'b0;
            if (drop_evt)       dropped <= 1'b1;
            else if (clr_drop)  dropped <= 1'b0;
        end
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && !fetch |=> busy); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        launch && busy |=> dropped && busy); // R3
    AST_MSG_KEEP: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(msg)); // R3
    AST_FETCH_DONE: assert property (@(posedge clk) disable iff (rst)
        fetch && busy |=> !busy && taken); // R4
    AST_IDLE_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch && !busy && !launch |=> !busy); // R4

endmodule

// File: rtl/mbx_tx_regs.sv
module mbx_tx_regs
    import mbx_tx_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NUM_CH-1:0] busy,
    input  logic [NUM_CH-1:0] dropped,
    input  logic [NUM_CH-1:0] taken,
    input  logic              pending,
    output payload_t          payload,
    output logic [NUM_CH-1:0] launch_vec,
    output logic [NUM_CH-1:0] clr_taken_vec,
    output logic [NUM_CH-1:0] clr_drop_vec,
    output irq_mask_t         mask,
    output logic              pend_clr,
    output logic [REG_W-1:0]  rdata
);

    logic [ID_W-1:0]    target_q;
    logic [REG_W-1:0]   low_q;
    logic [REG_W-1:0]   high_q;
    logic               launch_wr;
    logic               ack_wr;
    logic [FIELD_W-1:0] busy_f;
    logic [FIELD_W-1:0] drop_f;
    logic [FIELD_W-1:0] take_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            low_q    <= '0;
            high_q   <= '0;
            mask     <= MASK_RESET;
        end else if (we) begin
            case (addr)
                OFF_TARGET: target_q <= wdata[ID_W-1:0];
                OFF_LOW:    low_q    <= wdata;
                OFF_HIGH:   high_q   <= wdata;
                OFF_MASK:   mask     <= irq_mask_t'(wdata[2:0]);
                default: ;
            endcase
        end
    end

    assign payload   = '{high: high_q, low: low_q};
    assign launch_wr = we && (addr == OFF_LAUNCH) && wdata[0];
    assign ack_wr    = we && (addr == OFF_ACK);
    assign pend_clr  = we && (addr == OFF_PEND) && wdata[0];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign launch_vec[n]    = launch_wr && (target_q == ID_W'(n));
        assign clr_taken_vec[n] = ack_wr && wdata[TAKEN_LSB + n];
        assign clr_drop_vec[n]  = ack_wr && wdata[DROP_LSB + n];
    end

    always_comb begin
        busy_f = '0;
        drop_f = '0;
        take_f = '0;
        busy_f[NUM_CH-1:0] = busy;
        drop_f[NUM_CH-1:0] = dropped;
        take_f[NUM_CH-1:0] = taken;
        case (addr)
            OFF_TARGET: rdata = REG_W'(target_q);
            OFF_LOW:    rdata = low_q;
            OFF_HIGH:   rdata = high_q;
            OFF_STATUS: rdata = pack_status(busy_f, drop_f, take_f);
            OFF_PEND:   rdata = REG_W'(pending);
            OFF_MASK:   rdata = REG_W'(mask);
            default:    rdata = '0;
        endcase
    end

    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(launch_vec)); // R1

endmodule

// File: rtl/mbx_tx_irq.sv
module mbx_tx_irq
    import mbx_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take_evt,
    input  logic      drop_evt,
    input  logic      pend_clr,
    input  logic      any_taken,
    input  logic      any_dropped,
    input  irq_mask_t mask,
    output logic      pending,
    output logic      irq
);

    logic blocked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            if (take_evt || drop_evt) pending <= 1'b1;
            else if (pend_clr)        pending <= 1'b0;
            if (drop_evt)             blocked_q <= 1'b1;
            else if (pend_clr)        blocked_q <= 1'b0;
        end
    end

    assign irq = pending && ((any_taken   && !mask.taken)   ||
                             (any_dropped && !mask.dropped) ||
                             (blocked_q   && !mask.blocked));

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq |-> pending); // R8
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        pend_clr && !take_evt && !drop_evt |=> !pending && !irq); // R7
    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        take_evt || drop_evt |=> pending); // R7

endmodule

// File: rtl/mbx_tx_inbox.sv
module mbx_tx_inbox
    import mbx_tx_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int ID_W = $clog2(NUM_CH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] rmt_fetch,
    input  logic [ID_W-1:0]   rmt_sel,
    output logic [2*REG_W-1:0] rmt_msg,
    output logic              irq
);

    payload_t          payload;
    payload_t          slot_msg [NUM_CH];
    logic [NUM_CH-1:0] launch_vec, clr_taken_vec, clr_drop_vec;
    logic [NUM_CH-1:0] busy, taken, dropped, take_evt, drop_evt;
    irq_mask_t         mask;
    logic              pend_clr, pending;

    mbx_tx_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .dropped(dropped), .taken(taken), .pending(pending),
        .payload(payload), .launch_vec(launch_vec),
        .clr_taken_vec(clr_taken_vec), .clr_drop_vec(clr_drop_vec),
        .mask(mask), .pend_clr(pend_clr), .rdata(reg_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
        mbx_tx_slot u_slot (
            .clk(clk), .rst(rst), .launch(launch_vec[n]), .msg_in(payload),
            .fetch(rmt_fetch[n]), .clr_taken(clr_taken_vec[n]),
            .clr_drop(clr_drop_vec[n]), .busy(busy[n]), .taken(taken[n]),
            .dropped(dropped[n]), .msg(slot_msg[n]),
            .take_evt(take_evt[n]), .drop_evt(drop_evt[n])
        );
    end

    assign rmt_msg = slot_msg[rmt_sel];

    mbx_tx_irq u_irq (
        .clk(clk), .rst(rst), .take_evt(|take_evt), .drop_evt(|drop_evt),
        .pend_clr(pend_clr), .any_taken(|taken), .any_dropped(|dropped),
        .mask(mask), .pending(pending), .irq(irq)
    );

endmodule

// File: tb/mbx_tx_inbox_tb_top.sv
module mbx_tx_inbox_tb_top;

    localparam int CLK_P = 10;
    localparam int WDOG  = 20000;

    typedef struct {
        int          kind;   // 0 reg_rdata, 1 irq, 2 rmt_msg
        logic [63:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  rmt_fetch = '0;
    logic [2:0]  rmt_sel = '0;
    logic [63:0] rmt_msg;
    logic        irq;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mbx_tx_inbox dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rmt_fetch(rmt_fetch),
        .rmt_sel(rmt_sel), .rmt_msg(rmt_msg), .irq(irq)
    );

    // Monitor: compares queued expectations a quarter period after negedge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (q.size() > 0) begin
                exp_t e;
                logic [63:0] act;
                e = q.pop_front();
                case (e.kind)
                    0: act = {32'h0, reg_rdata};
                    1: act = {63'h0, irq};
                    default: act = rmt_msg;
                endcase
                n_chk++;
                if (act !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, act, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] m);
        @(negedge clk);
        rmt_fetch = m;
        @(negedge clk);
        rmt_fetch = '0;
    endtask

    task automatic chk_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        q.push_back('{kind: 0, exp: {32'h0, e}, tag: tag});
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        q.push_back('{kind: 1, exp: {63'h0, e}, tag: tag});
    endtask

    task automatic chk_msg(input logic [2:0] s, input logic [63:0] e, input string tag);
        @(negedge clk);
        rmt_sel = s;
        q.push_back('{kind: 2, exp: e, tag: tag});
    endtask

    task automatic send(input logic [2:0] id, input logic [31:0] lo, input logic [31:0] hi);
        wr(6'h04, lo);
        wr(6'h08, hi);
        wr(6'h00, {29'h0, id});
        wr(6'h0C, 32'h1);
    endtask

    task automatic finish_run();
        @(negedge clk);
        #(CLK_P/2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_reg(6'h14, 32'h0, "R9 status after reset");
        chk_reg(6'h18, 32'h0, "R9 pending after reset");
        chk_irq(1'b0, "R9 irq after reset");
        chk_reg(6'h1C, 32'h7, "R6 mask reset value");

        // Single send to destination 3
        send(3'd3, 32'hA5A5_0001, 32'h5A5A_1001);
        chk_reg(6'h14, 32'h0000_0008, "R1 busy bit 3");
        chk_msg(3'd3, 64'h5A5A_1001_A5A5_0001, "R2 slot 3 payload");
        chk_reg(6'h04, 32'hA5A5_0001, "R10 low readback");
        chk_reg(6'h08, 32'h5A5A_1001, "R10 high readback");
        chk_reg(6'h00, 32'h3, "R10 target readback");

        // Launch into occupied slot
        send(3'd3, 32'hDEAD_0000, 32'hBEEF_0000);
        chk_reg(6'h14, 32'h0000_0808, "R3 dropped bit 11 busy kept");
        chk_msg(3'd3, 64'h5A5A_1001_A5A5_0001, "R3 payload not overwritten");
        chk_reg(6'h18, 32'h1, "R7 pending after drop");
        chk_irq(1'b0, "R6 all causes masked");
        wr(6'h1C, 32'h5);
        chk_irq(1'b1, "R8 dropped cause unmasked");
        wr(6'h18, 32'h1);
        chk_irq(1'b0, "R7 pending cleared drops irq");
        chk_reg(6'h18, 32'h0, "R7 pending reads 0");

        // Fetch by remote side
        fetch(8'h08);
        chk_reg(6'h14, 32'h0008_0800, "R4 busy cleared taken set");
        chk_irq(1'b1, "R8 pending with dropped unmasked");
        wr(6'h10, 32'h0000_0800);
        chk_reg(6'h14, 32'h0008_0000, "R5 dropped bit cleared only");
        chk_irq(1'b0, "R6 taken cause masked");
        wr(6'h1C, 32'h1);
        chk_irq(1'b1, "R8 taken cause unmasked");
        wr(6'h10, 32'h0008_0000);
        chk_reg(6'h14, 32'h0, "R5 taken bit cleared");
        chk_irq(1'b0, "R8 no active cause");

        // Ignored stimuli
        fetch(8'h20);
        chk_reg(6'h14, 32'h0, "R4 fetch on idle slot ignored");
        wr(6'h0C, 32'h0);
        chk_reg(6'h14, 32'h0, "R1 launch with bit0 low ignored");

        // Two destinations, fetched together
        send(3'd0, 32'h1111_0000, 32'h2222_0000);
        send(3'd7, 32'h3333_0007, 32'h4444_0007);
        chk_reg(6'h14, 32'h0000_0081, "R1 busy bits 0 and 7");
        chk_msg(3'd0, 64'h2222_0000_1111_0000, "R2 slot 0 payload");
        chk_msg(3'd7, 64'h4444_0007_3333_0007, "R2 slot 7 payload");
        wr(6'h10, 32'h00FF_FF00);
        chk_reg(6'h14, 32'h0000_0081, "R5 ack leaves busy bits");
        fetch(8'h81);
        chk_reg(6'h14, 32'h0081_0000, "R4 both taken");
        wr(6'h10, 32'h0001_0000);
        chk_reg(6'h14, 32'h0080_0000, "R5 partial clear keeps bit 23");

        // Dropped-launch cause alone
        wr(6'h18, 32'h1);
        wr(6'h1C, 32'h6);
        send(3'd2, 32'h0000_0C02, 32'h0000_0D02);
        chk_irq(1'b0, "R8 no drop yet");
        wr(6'h0C, 32'h1);
        chk_irq(1'b1, "R8 blocked cause after drop");
        chk_reg(6'h14, 32'h0080_0404, "R3 dropped bit 10 busy bit 2");
        wr(6'h18, 32'h1);
        chk_irq(1'b0, "R8 blocked cause cleared with pending");

        done = 1'b1;
        finish_run();
    end

endmodule